// File: doc/BRIEF.md
# One-Way Non-Maskable Mailbox

This block carries one data word and a non-maskable interrupt from a sending core to a receiving core. The sender polls a data-register-empty flag. It may load a word only while that flag is high. An accepted load fills the data register, drops the empty flag and raises a pending flag. The pending flag drives the interrupt line toward the receiver for as long as it is set.

The receiver reads the word through a read-only data output. It strobes a read pulse when it has taken the word, and that pulse marks the register empty again. The pending flag is not touched by that read, and no sender write can clear it. It is cleared only by a one-cycle serviced pulse from the receiver. A new load that arrives in the same cycle as a serviced pulse keeps the flag set.

Top module: `nmi_mailbox`

## Requirements
- R1: After reset the status output reads empty=1 (bit 0) and pending=0 (bit 1), the interrupt line is low and the receive data output is zero.
- R2: A sender write while empty=1 is accepted. One cycle later the receive data output shows the written word, empty=0 and pending=1.
- R3: A sender write while empty=0 is dropped. The data word stays unchanged and the write does not mark the register empty.
- R4: A receiver read pulse while empty=0 sets empty=1 one cycle later and leaves the data output unchanged.
- R5: A receiver read pulse never clears pending.
- R6: No sender write clears pending, including a write of all ones.
- R7: A serviced pulse clears pending and drops the interrupt one cycle later, and it leaves empty unchanged.
- R8: When a serviced pulse and an accepted write fall in the same cycle, pending is set one cycle later.
- R9: The interrupt line rises only in the cycle after an accepted write, and it stays equal to the pending status bit.
- R10: A receiver read pulse while empty=1 has no effect on the status or the data output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| snd_we | input | 1 | Sender write strobe for the data register |
| snd_wdata | input | DATA_W | Sender write data |
| snd_status | output | 2 | Sender status: bit 0 empty, bit 1 pending |
| rcv_rd | input | 1 | Receiver read pulse, marks the word as taken |
| rcv_rdata | output | DATA_W | Receiver read-only data |
| rcv_serviced | input | 1 | One-cycle pulse: the receiver has serviced the interrupt |
| nmi | output | 1 | Non-maskable interrupt toward the receiver |

## Verification
Every result is due exactly one clock edge after the stimulus cycle: a write, read or serviced strobe held across one rising edge changes the data, status and interrupt outputs at that edge. Deassertion of reset reaches the logic two edges late through the synchronizer. The bench drives strobes on the falling edge, holds them across one rising edge and samples on the next falling edge. It waits three edges after reset release before its first check. The collision cases drive two strobes together in one cycle so that the priority result is visible on the single edge that follows.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned STAT_W         = 2;
  localparam int unsigned STAT_EMPTY_BIT = 0;
  localparam int unsigned STAT_PEND_BIT  = 1;

  typedef struct packed {
    logic pend;
    logic empty;
  } mbx_stat_t;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_data_reg.sv
module mbx_data_reg #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (load) word_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= word_d;
  end

  assign dout = word_q;
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags
  import mbx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_req,
  input  logic      rd_req,
  input  logic      svc,
  output logic      wr_accept,
  output mbx_stat_t stat
);
  mbx_stat_t stat_q;
  mbx_stat_t stat_d;
  logic      rd_release;
  logic      flag_en;

  always_comb begin
    wr_accept  = wr_req & stat_q.empty;
    rd_release = rd_req & ~stat_q.empty;
    flag_en    = wr_accept | rd_release | svc;
    stat_d     = stat_q;
    // empty: an accepted load fills, a read of a full register drains
    if (wr_accept)       stat_d.empty = 1'b0;
    else if (rd_release) stat_d.empty = 1'b1;
    // pending: a set from a new load beats a simultaneous serviced pulse
    if (wr_accept)       stat_d.pend = 1'b1;
    else if (svc)        stat_d.pend = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '{pend: 1'b0, empty: 1'b1};
    else if (flag_en) stat_q <= stat_d;
  end

  assign stat = stat_q;
endmodule

// File: rtl/nmi_mailbox.sv
module nmi_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W    = 24,
  parameter int unsigned RST_SYNC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snd_we,
  input  logic [DATA_W-1:0] snd_wdata,
  output logic [STAT_W-1:0] snd_status,
  input  logic              rcv_rd,
  output logic [DATA_W-1:0] rcv_rdata,
  input  logic              rcv_serviced,
  output logic              nmi
);
  logic      rst_n_sync;
  logic      wr_accept;
  mbx_stat_t stat;

  mbx_rst_sync #(.STAGES(RST_SYNC)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  mbx_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .wr_req    (snd_we),
    .rd_req    (rcv_rd),
    .svc       (rcv_serviced),
    .wr_accept (wr_accept),
    .stat      (stat)
  );

  mbx_data_reg #(.DATA_W(DATA_W)) u_data (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .load  (wr_accept),
    .din   (snd_wdata),
    .dout  (rcv_rdata)
  );

  always_comb begin
    snd_status                 = '0;
    snd_status[STAT_EMPTY_BIT] = stat.empty;
    snd_status[STAT_PEND_BIT]  = stat.pend;
  end

  assign nmi = stat.pend;
endmodule

// File: rtl/nmi_mailbox_chk.sv
module nmi_mailbox_chk #(
  parameter int unsigned DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              snd_we,
  input logic [DATA_W-1:0] snd_wdata,
  input logic [1:0]        snd_status,
  input logic              rcv_rd,
  input logic [DATA_W-1:0] rcv_rdata,
  input logic              rcv_serviced,
  input logic              nmi
);
  logic empty;
  logic pend;
  assign empty = snd_status[0];
  assign pend  = snd_status[1];

  AST_WR_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    snd_we && empty |=> !empty && pend && rcv_rdata == $past(snd_wdata)); // R2

  AST_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    snd_we && !empty && !rcv_rd |=> !empty && $stable(rcv_rdata)); // R3

  AST_RD_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_rd && !empty |=> empty && $stable(rcv_rdata)); // R4

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !rcv_serviced |=> pend); // R5

  AST_SVC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_serviced && !(snd_we && empty) |=> !pend && !nmi); // R7

  AST_SVC_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_serviced && snd_we && empty |=> pend); // R8

  AST_NMI_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi) |-> $past(snd_we && empty)); // R9

  AST_NMI_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    nmi == pend); // R9

  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_rd && empty && !snd_we && !rcv_serviced |=> $stable(snd_status) && $stable(rcv_rdata)); // R10
endmodule

bind nmi_mailbox nmi_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_sync),
  .snd_we       (snd_we),
  .snd_wdata    (snd_wdata),
  .snd_status   (snd_status),
  .rcv_rd       (rcv_rd),
  .rcv_rdata    (rcv_rdata),
  .rcv_serviced (rcv_serviced),
  .nmi          (nmi)
);

// File: tb/nmi_mailbox_test.sv
module nmi_mailbox_test;
  localparam int  CLK_PERIOD = 10;
  localparam int  DATA_W     = 24;
  localparam int  WATCHDOG   = 5000;

  logic              clk;
  logic              rst_n;
  logic              snd_we;
  logic [DATA_W-1:0] snd_wdata;
  logic [1:0]        snd_status;
  logic              rcv_rd;
  logic [DATA_W-1:0] rcv_rdata;
  logic              rcv_serviced;
  logic              nmi;

  int checks = 0;
  int fails  = 0;

  nmi_mailbox #(.DATA_W(DATA_W)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .snd_we       (snd_we),
    .snd_wdata    (snd_wdata),
    .snd_status   (snd_status),
    .rcv_rd       (rcv_rd),
    .rcv_rdata    (rcv_rdata),
    .rcv_serviced (rcv_serviced),
    .nmi          (nmi)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive strobes for one rising edge, then sample on the next falling edge
  task automatic cycle(input logic we, input logic [DATA_W-1:0] d,
                       input logic rd, input logic svc);
    snd_we = we; snd_wdata = d; rcv_rd = rd; rcv_serviced = svc;
    @(negedge clk);
    snd_we = 1'b0; rcv_rd = 1'b0; rcv_serviced = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; snd_we = 1'b0; snd_wdata = '0; rcv_rd = 1'b0; rcv_serviced = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 status", 32'(snd_status), 32'h1);
    chk("R1 nmi",    32'(nmi),        32'h0);
    chk("R1 rdata",  32'(rcv_rdata),  32'h0);
  endtask

  task automatic t_accept;
    cycle(1'b1, 24'hA5C3_1E, 1'b0, 1'b0);
    chk("R2 rdata",  32'(rcv_rdata),  32'h00A5C31E);
    chk("R2 status", 32'(snd_status), 32'h2);
    chk("R9 nmi",    32'(nmi),        32'h1);
  endtask

  task automatic t_drop_all_ones;
    cycle(1'b1, {DATA_W{1'b1}}, 1'b0, 1'b0);
    chk("R3 rdata",  32'(rcv_rdata),  32'h00A5C31E);
    chk("R3 empty",  32'(snd_status[0]), 32'h0);
    chk("R6 pend",   32'(snd_status[1]), 32'h1);
  endtask

  task automatic t_read;
    cycle(1'b0, '0, 1'b1, 1'b0);
    chk("R4 empty",  32'(snd_status[0]), 32'h1);
    chk("R4 rdata",  32'(rcv_rdata),  32'h00A5C31E);
    chk("R5 pend",   32'(snd_status[1]), 32'h1);
    chk("R9 nmi",    32'(nmi),        32'h1);
  endtask

  task automatic t_idle_read;
    cycle(1'b0, '0, 1'b1, 1'b0);
    chk("R10 status", 32'(snd_status), 32'h3);
    chk("R10 rdata",  32'(rcv_rdata),  32'h00A5C31E);
  endtask

  task automatic t_service;
    cycle(1'b0, '0, 1'b0, 1'b1);
    chk("R7 status", 32'(snd_status), 32'h1);
    chk("R7 nmi",    32'(nmi),        32'h0);
    cycle(1'b0, '0, 1'b0, 1'b1);
    chk("R7 idle svc", 32'(snd_status), 32'h1);
  endtask

  task automatic t_collide;
    cycle(1'b1, 24'h0F_7722, 1'b0, 1'b1);
    chk("R8 status", 32'(snd_status), 32'h2);
    chk("R8 rdata",  32'(rcv_rdata),  32'h000F7722);
    chk("R9 nmi",    32'(nmi),        32'h1);
  endtask

  task automatic t_drop_with_read;
    cycle(1'b1, 24'h12_3456, 1'b1, 1'b0);
    chk("R3 drop+read empty", 32'(snd_status), 32'h3);
    chk("R3 drop+read rdata", 32'(rcv_rdata),  32'h000F7722);
    cycle(1'b1, 24'h00_0BEE, 1'b0, 1'b0);
    chk("R6 re-load pend", 32'(snd_status), 32'h2);
    chk("R2 re-load rdata", 32'(rcv_rdata), 32'h00000BEE);
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_accept;
    t_drop_all_ones;
    t_read;
    t_idle_read;
    t_service;
    t_collide;
    t_drop_with_read;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule